// File: doc/BRIEF.md
# DRAM Software Command Injector

This block lets a processor drive a DDR3 memory interface by hand while the memory is being brought up. Four staged registers are loaded over a Wishbone classic bus: a control word, a command word, a row address and a bank address. A write to a separate issue register places the staged command on the phase-0 DFI-style command outputs for exactly one clock cycle. In every other cycle the command pins show a deselect.

The control word drives the memory reset, clock-enable and on-die-termination pins directly. One of its bits hands the whole interface to the normal memory controller. While that bit is set, the controller's signals reach the outputs unchanged.

Software brings the memory up in a fixed order. It releases reset and enables termination, then raises clock-enable. Next it issues the mode-register loads and a ZQ calibration. Each of these commands is one staged command followed by one issue write.

Top module: `dram_sw_injector`

## Requirements
- R1: After reset the control word is 0. In that state software owns the interface, `dfi_reset_n` is 0, and `dfi_cke` and `dfi_odt` are 0. All four active-low command outputs are 1.
- R2: The control word uses these bits: bit 1 sets `dfi_cke`, bit 2 sets `dfi_odt` and bit 3 sets `dfi_reset_n`. The new levels are on the pins in the same cycle that `wb_ack` is high for the write, so 0x0C gives reset released and ODT on, and 0x0E also gives CKE on.
- R3: A write to the command word (word index 1) does not drive any command pin low, neither in its acknowledge cycle nor in the next cycle.
- R4: A write to the issue register (word index 2) with data bit 0 set drives the staged command for exactly one cycle, the cycle in which `wb_ack` is high. The command word bits map as bit 0 to CS, bit 1 to WE, bit 2 to CAS and bit 3 to RAS, and each output pin is the inverse of its bit. The value 0x0F therefore gives a mode-register set with all four pins low.
- R5: In the issue cycle the staged address (word index 3) and bank (word index 4) appear on `dfi_address` and `dfi_bank`. For example, bank 2 with address 0x200 selects MR2. A value of 0x03 with address bit 10 set gives a ZQ long calibration, with `dfi_cs_n` and `dfi_we_n` low and the other two pins high.
- R6: A write to the issue register with data bit 0 clear issues no command.
- R7: Reads of the control word, command word, address and bank return the last value written, cut to 4, 4, ROW_W and BANK_W bits. The issue register reads as 0.
- R8: While control bit 0 is set, every DFI output equals the corresponding `hw_*` input.
- R9: Each bus access with `wb_cyc` and `wb_stb` high gets `wb_ack` for one cycle, on the clock edge after the request. Read data is valid in that ack cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | ADR_W | Word address |
| wb_dat_w | input | DATA_W | Write data |
| wb_dat_r | output | DATA_W | Read data |
| wb_ack | output | 1 | Acknowledge |
| hw_cs_n | input | 1 | Controller chip select, active low |
| hw_ras_n | input | 1 | Controller RAS, active low |
| hw_cas_n | input | 1 | Controller CAS, active low |
| hw_we_n | input | 1 | Controller WE, active low |
| hw_address | input | ROW_W | Controller address |
| hw_bank | input | BANK_W | Controller bank |
| hw_cke | input | 1 | Controller clock enable |
| hw_odt | input | 1 | Controller termination enable |
| hw_reset_n | input | 1 | Controller memory reset, active low |
| dfi_cs_n | output | 1 | Chip select to the PHY |
| dfi_ras_n | output | 1 | RAS to the PHY |
| dfi_cas_n | output | 1 | CAS to the PHY |
| dfi_we_n | output | 1 | WE to the PHY |
| dfi_address | output | ROW_W | Address to the PHY |
| dfi_bank | output | BANK_W | Bank to the PHY |
| dfi_cke | output | 1 | Clock enable to the PHY |
| dfi_odt | output | 1 | Termination enable to the PHY |
| dfi_reset_n | output | 1 | Memory reset to the PHY, active low |

## Verification
Some checks run on every cycle. A command pin can go low under software ownership only in the cycle after an issue write with bit 0 set, and it returns to deselect one cycle later. A control write under software ownership moves the reset, CKE and ODT pins by its own ack cycle. Under hardware ownership the outputs follow the controller, and every request is acknowledged on the next edge.

Other behaviour needs the bench's scenarios to show it. These are the exact pin patterns of the mode-register and ZQ commands with their address and bank, and the fact that command-only or bit-0-clear writes issue nothing. They also include read-back width truncation, the zero read of the issue register, and the reset values as seen over the bus.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
   // word indices of the register file
   localparam int unsigned IDX_CTRL  = 0;
   localparam int unsigned IDX_CMD   = 1;
   localparam int unsigned IDX_ISSUE = 2;
   localparam int unsigned IDX_ADDR  = 3;
   localparam int unsigned IDX_BANK  = 4;
   // control word bits
   localparam int unsigned CTL_HWOWN = 0;
   localparam int unsigned CTL_CKE   = 1;
   localparam int unsigned CTL_ODT   = 2;
   localparam int unsigned CTL_RSTRL = 3;
   // command word bits (active-high staging, inverted on the pins)
   localparam int unsigned CMD_CS    = 0;
   localparam int unsigned CMD_WE    = 1;
   localparam int unsigned CMD_CAS   = 2;
   localparam int unsigned CMD_RAS   = 3;
   localparam int unsigned CTL_W     = 4;
   localparam int unsigned CMD_W     = 4;
endpackage

// File: rtl/dsi_regs.sv
module dsi_regs
   import dsi_pkg::*;
#(
   parameter int unsigned ADR_W       = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ROW_W       = 16,
   parameter int unsigned BANK_W      = 3,
   parameter bit          FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cyc,
   input  logic              stb,
   input  logic              we,
   input  logic [ADR_W-1:0]  adr,
   input  logic [DATA_W-1:0] dat_w,
   output logic [DATA_W-1:0] dat_r,
   output logic              ack,
   output logic [CTL_W-1:0]  ctrl,
   output logic [CMD_W-1:0]  cmd,
   output logic [ROW_W-1:0]  addr,
   output logic [BANK_W-1:0] bank,
   output logic              fire
);
   localparam int unsigned DEC_W = FULL_DECODE ? ADR_W : 3;

   logic              access;
   logic              wr;
   logic [DEC_W-1:0]  idx;
   logic [DATA_W-1:0] rd_val;

   generate
      if (FULL_DECODE) begin : g_full
         assign idx = adr;
      end else begin : g_alias
         assign idx = adr[2:0];
      end
   endgenerate

   assign access = cyc & stb & ~ack;
   assign wr     = access & we;

   always_comb begin
      rd_val = '0;
      case (idx)
         DEC_W'(IDX_CTRL): rd_val = DATA_W'(ctrl);
         DEC_W'(IDX_CMD):  rd_val = DATA_W'(cmd);
         DEC_W'(IDX_ADDR): rd_val = DATA_W'(addr);
         DEC_W'(IDX_BANK): rd_val = DATA_W'(bank);
         default:          rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ack   <= 1'b0;
         fire  <= 1'b0;
         ctrl  <= '0;
         cmd   <= '0;
         addr  <= '0;
         bank  <= '0;
         dat_r <= '0;
      end else begin
         ack  <= access;
         fire <= wr && (idx == DEC_W'(IDX_ISSUE)) && dat_w[0];
         if (access) dat_r <= rd_val;
         if (wr) begin
            case (idx)
               DEC_W'(IDX_CTRL): ctrl <= dat_w[CTL_W-1:0];
               DEC_W'(IDX_CMD):  cmd  <= dat_w[CMD_W-1:0];
               DEC_W'(IDX_ADDR): addr <= dat_w[ROW_W-1:0];
               DEC_W'(IDX_BANK): bank <= dat_w[BANK_W-1:0];
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dsi_mux.sv
module dsi_mux
   import dsi_pkg::*;
#(
   parameter int unsigned ROW_W  = 16,
   parameter int unsigned BANK_W = 3
) (
   input  logic [CTL_W-1:0]  ctrl,
   input  logic [CMD_W-1:0]  cmd,
   input  logic              fire,
   input  logic [ROW_W-1:0]  sw_addr,
   input  logic [BANK_W-1:0] sw_bank,
   input  logic              hw_cs_n,
   input  logic              hw_ras_n,
   input  logic              hw_cas_n,
   input  logic              hw_we_n,
   input  logic [ROW_W-1:0]  hw_address,
   input  logic [BANK_W-1:0] hw_bank,
   input  logic              hw_cke,
   input  logic              hw_odt,
   input  logic              hw_reset_n,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ROW_W-1:0]  address,
   output logic [BANK_W-1:0] bank,
   output logic              cke,
   output logic              odt,
   output logic              reset_n
);
   logic [CMD_W-1:0] live;
   logic             hw_sel;

   assign hw_sel = ctrl[CTL_HWOWN];
   // staged bits reach the pins only in the issue cycle
   assign live   = fire ? cmd : '0;

   always_comb begin
      if (hw_sel) begin
         cs_n    = hw_cs_n;
         ras_n   = hw_ras_n;
         cas_n   = hw_cas_n;
         we_n    = hw_we_n;
         address = hw_address;
         bank    = hw_bank;
         cke     = hw_cke;
         odt     = hw_odt;
         reset_n = hw_reset_n;
      end else begin
         cs_n    = ~live[CMD_CS];
         ras_n   = ~live[CMD_RAS];
         cas_n   = ~live[CMD_CAS];
         we_n    = ~live[CMD_WE];
         address = sw_addr;
         bank    = sw_bank;
         cke     = ctrl[CTL_CKE];
         odt     = ctrl[CTL_ODT];
         reset_n = ctrl[CTL_RSTRL];
      end
   end
endmodule

// File: rtl/dram_sw_injector.sv
module dram_sw_injector
   import dsi_pkg::*;
#(
   parameter int unsigned ADR_W       = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ROW_W       = 16,
   parameter int unsigned BANK_W      = 3,
   parameter bit          FULL_DECODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wb_cyc,
   input  logic              wb_stb,
   input  logic              wb_we,
   input  logic [ADR_W-1:0]  wb_adr,
   input  logic [DATA_W-1:0] wb_dat_w,
   output logic [DATA_W-1:0] wb_dat_r,
   output logic              wb_ack,
   input  logic              hw_cs_n,
   input  logic              hw_ras_n,
   input  logic              hw_cas_n,
   input  logic              hw_we_n,
   input  logic [ROW_W-1:0]  hw_address,
   input  logic [BANK_W-1:0] hw_bank,
   input  logic              hw_cke,
   input  logic              hw_odt,
   input  logic              hw_reset_n,
   output logic              dfi_cs_n,
   output logic              dfi_ras_n,
   output logic              dfi_cas_n,
   output logic              dfi_we_n,
   output logic [ROW_W-1:0]  dfi_address,
   output logic [BANK_W-1:0] dfi_bank,
   output logic              dfi_cke,
   output logic              dfi_odt,
   output logic              dfi_reset_n
);
   generate
      if (ADR_W < 3) begin : g_bad_adr
         $error("ADR_W must cover five word indices");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (ROW_W < 11 || ROW_W > DATA_W) begin : g_bad_row
         $error("ROW_W must hold bit 10 and fit in DATA_W");
      end
      if (BANK_W < 1 || BANK_W > DATA_W) begin : g_bad_bank
         $error("BANK_W out of range");
      end
   endgenerate

   logic [CTL_W-1:0]  ctrl_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [ROW_W-1:0]  addr_q;
   logic [BANK_W-1:0] bank_q;
   logic              fire_q;
   logic              hw_own;

   assign hw_own = ctrl_q[CTL_HWOWN];

   dsi_regs #(
      .ADR_W(ADR_W), .DATA_W(DATA_W), .ROW_W(ROW_W),
      .BANK_W(BANK_W), .FULL_DECODE(FULL_DECODE)
   ) u_regs (
      .clk(clk), .rst(rst), .cyc(wb_cyc), .stb(wb_stb), .we(wb_we),
      .adr(wb_adr), .dat_w(wb_dat_w), .dat_r(wb_dat_r), .ack(wb_ack),
      .ctrl(ctrl_q), .cmd(cmd_q), .addr(addr_q), .bank(bank_q), .fire(fire_q)
   );

   dsi_mux #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_mux (
      .ctrl(ctrl_q), .cmd(cmd_q), .fire(fire_q),
      .sw_addr(addr_q), .sw_bank(bank_q),
      .hw_cs_n(hw_cs_n), .hw_ras_n(hw_ras_n), .hw_cas_n(hw_cas_n),
      .hw_we_n(hw_we_n), .hw_address(hw_address), .hw_bank(hw_bank),
      .hw_cke(hw_cke), .hw_odt(hw_odt), .hw_reset_n(hw_reset_n),
      .cs_n(dfi_cs_n), .ras_n(dfi_ras_n), .cas_n(dfi_cas_n), .we_n(dfi_we_n),
      .address(dfi_address), .bank(dfi_bank),
      .cke(dfi_cke), .odt(dfi_odt), .reset_n(dfi_reset_n)
   );
endmodule

// File: rtl/dsi_checker.sv
module dsi_checker #(
   parameter int unsigned ADR_W  = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ROW_W  = 16,
   parameter int unsigned BANK_W = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              wb_cyc,
   input logic              wb_stb,
   input logic              wb_we,
   input logic [ADR_W-1:0]  wb_adr,
   input logic [DATA_W-1:0] wb_dat_w,
   input logic              wb_ack,
   input logic              hw_own,
   input logic              hw_cs_n,
   input logic              hw_cke,
   input logic              hw_reset_n,
   input logic [ROW_W-1:0]  hw_address,
   input logic              dfi_cs_n,
   input logic              dfi_ras_n,
   input logic              dfi_cas_n,
   input logic              dfi_we_n,
   input logic              dfi_cke,
   input logic              dfi_odt,
   input logic              dfi_reset_n,
   input logic [ROW_W-1:0]  dfi_address
);
   logic req, issue_wr, ctl_wr_sw, any_low;
   assign req       = wb_cyc & wb_stb & ~wb_ack;
   assign issue_wr  = req & wb_we & (wb_adr == ADR_W'(2)) & wb_dat_w[0];
   assign ctl_wr_sw = req & wb_we & (wb_adr == ADR_W'(0)) & ~wb_dat_w[0];
   assign any_low   = ~(dfi_cs_n & dfi_ras_n & dfi_cas_n & dfi_we_n);

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!dfi_reset_n && !dfi_cke && !dfi_odt && !any_low)); // R1

   AST_CTRL_PINS: assert property (@(posedge clk) disable iff (rst)
      $past(ctl_wr_sw) |-> (dfi_cke == $past(wb_dat_w[1]) && dfi_odt == $past(wb_dat_w[2])
                            && dfi_reset_n == $past(wb_dat_w[3]))); // R2

   AST_CMD_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
      (!hw_own && any_low) |-> $past(issue_wr)); // R4

   AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (!hw_own && any_low && !issue_wr) |=> (hw_own || !any_low)); // R4

   AST_HW_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      hw_own |-> (dfi_cs_n == hw_cs_n && dfi_cke == hw_cke && dfi_reset_n == hw_reset_n
                  && dfi_address == hw_address)); // R8

   AST_ACK_NEXT: assert property (@(posedge clk) disable iff (rst)
      req |=> wb_ack); // R9

   AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
      wb_ack |-> $past(wb_cyc & wb_stb)); // R9
endmodule

bind dram_sw_injector dsi_checker #(
   .ADR_W(ADR_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .BANK_W(BANK_W)
) u_chk (
   .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
   .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_ack(wb_ack), .hw_own(hw_own),
   .hw_cs_n(hw_cs_n), .hw_cke(hw_cke), .hw_reset_n(hw_reset_n),
   .hw_address(hw_address), .dfi_cs_n(dfi_cs_n), .dfi_ras_n(dfi_ras_n),
   .dfi_cas_n(dfi_cas_n), .dfi_we_n(dfi_we_n), .dfi_cke(dfi_cke),
   .dfi_odt(dfi_odt), .dfi_reset_n(dfi_reset_n), .dfi_address(dfi_address)
);

// File: tb/sim_dram_sw_injector.sv
module sim_dram_sw_injector;
   localparam int CLK_PERIOD = 10;
   localparam int ADR_W = 4, DATA_W = 32, ROW_W = 16, BANK_W = 3;

   logic clk = 1'b0, rst = 1'b1;
   logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
   logic [ADR_W-1:0]  wb_adr = '0;
   logic [DATA_W-1:0] wb_dat_w = '0;
   logic [DATA_W-1:0] wb_dat_r;
   logic wb_ack;
   logic hw_cs_n = 0, hw_ras_n = 1, hw_cas_n = 0, hw_we_n = 1;
   logic [ROW_W-1:0]  hw_address = 16'hA5A5;
   logic [BANK_W-1:0] hw_bank = 3'd5;
   logic hw_cke = 1, hw_odt = 0, hw_reset_n = 1;
   logic dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n, dfi_cke, dfi_odt, dfi_reset_n;
   logic [ROW_W-1:0]  dfi_address;
   logic [BANK_W-1:0] dfi_bank;

   int vectors = 0, miscompares = 0;
   logic [3:0]        s_pins;   // {ras_n,cas_n,we_n,cs_n} in ack cycle
   logic [ROW_W-1:0]  s_addr;
   logic [BANK_W-1:0] s_bank;
   logic [2:0]        s_ctl;    // {reset_n,odt,cke}
   logic              s_ack;
   logic [DATA_W-1:0] s_rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_sw_injector #(.ADR_W(ADR_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .BANK_W(BANK_W)) u0 (
      .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
      .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
      .hw_cs_n(hw_cs_n), .hw_ras_n(hw_ras_n), .hw_cas_n(hw_cas_n), .hw_we_n(hw_we_n),
      .hw_address(hw_address), .hw_bank(hw_bank), .hw_cke(hw_cke), .hw_odt(hw_odt),
      .hw_reset_n(hw_reset_n), .dfi_cs_n(dfi_cs_n), .dfi_ras_n(dfi_ras_n),
      .dfi_cas_n(dfi_cas_n), .dfi_we_n(dfi_we_n), .dfi_address(dfi_address),
      .dfi_bank(dfi_bank), .dfi_cke(dfi_cke), .dfi_odt(dfi_odt), .dfi_reset_n(dfi_reset_n)
   );

   function automatic logic [3:0] pins();
      return {dfi_ras_n, dfi_cas_n, dfi_we_n, dfi_cs_n};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus(input logic wr, input int idx, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wb_cyc = 1; wb_stb = 1; wb_we = wr; wb_adr = ADR_W'(idx); wb_dat_w = d;
      @(negedge clk);
      s_ack = wb_ack; s_pins = pins(); s_addr = dfi_address; s_bank = dfi_bank;
      s_ctl = {dfi_reset_n, dfi_odt, dfi_cke}; s_rd = wb_dat_r;
      wb_cyc = 0; wb_stb = 0; wb_we = 0;
   endtask

   task automatic t_reset();
      check("R1 ctl pins", {29'd0, dfi_reset_n, dfi_odt, dfi_cke}, 32'h0);
      check("R1 cmd idle", {28'd0, pins()}, 32'hF);
      bus(0, 0, 0);
      check("R1 ctrl read", s_rd, 32'h0);
      check("R9 read ack", {31'd0, s_ack}, 32'h1);
      @(negedge clk);
      check("R9 ack drops", {31'd0, wb_ack}, 32'h0);
   endtask

   task automatic t_control();
      bus(1, 0, 32'h0C);
      check("R2 0x0C pins", {29'd0, s_ctl}, 32'b110);
      bus(1, 0, 32'h0E);
      check("R2 0x0E pins", {29'd0, s_ctl}, 32'b111);
   endtask

   task automatic t_cmd_alone();
      bus(1, 1, 32'h0F);
      check("R3 ack cycle", {28'd0, s_pins}, 32'hF);
      @(negedge clk);
      check("R3 next cycle", {28'd0, pins()}, 32'hF);
   endtask

   task automatic t_mrs();
      bus(1, 3, 32'h200);
      bus(1, 4, 32'h2);
      bus(1, 1, 32'h0F);
      bus(1, 2, 32'h1);
      check("R4 mrs pins", {28'd0, s_pins}, 32'h0);
      check("R5 mrs addr", {16'd0, s_addr}, 32'h200);
      check("R5 mrs bank", {29'd0, s_bank}, 32'h2);
      @(negedge clk);
      check("R4 one cycle", {28'd0, pins()}, 32'hF);
   endtask

   task automatic t_zq();
      bus(1, 3, 32'h400);
      bus(1, 4, 32'h0);
      bus(1, 1, 32'h03);
      bus(1, 2, 32'h1);
      check("R5 zq pins", {28'd0, s_pins}, 32'b1100);
      check("R5 zq a10", {31'd0, s_addr[10]}, 32'h1);
      @(negedge clk);
      check("R4 zq ends", {28'd0, pins()}, 32'hF);
   endtask

   task automatic t_issue_zero();
      bus(1, 2, 32'h0);
      check("R6 no issue", {28'd0, s_pins}, 32'hF);
      @(negedge clk);
      check("R6 no issue next", {28'd0, pins()}, 32'hF);
   endtask

   task automatic t_readback();
      bus(1, 3, 32'h0001_2345);
      bus(0, 3, 0);
      check("R7 addr trunc", s_rd, 32'h2345);
      bus(1, 4, 32'hFF);
      bus(0, 4, 0);
      check("R7 bank trunc", s_rd, 32'h7);
      bus(0, 1, 0);
      check("R7 cmd read", s_rd, 32'h3);
      bus(0, 0, 0);
      check("R7 ctrl read", s_rd, 32'hE);
      bus(0, 2, 0);
      check("R7 issue reads 0", s_rd, 32'h0);
   endtask

   task automatic t_hw_own();
      bus(1, 0, 32'h1);
      @(negedge clk);
      check("R8 cmd pass", {28'd0, pins()}, {28'd0, hw_ras_n, hw_cas_n, hw_we_n, hw_cs_n});
      check("R8 addr pass", {16'd0, dfi_address}, 32'hA5A5);
      check("R8 bank pass", {29'd0, dfi_bank}, 32'd5);
      check("R8 ctl pass", {29'd0, dfi_reset_n, dfi_odt, dfi_cke}, 32'b101);
      hw_cs_n = 1; hw_address = 16'h0F0F; hw_odt = 1;
      @(negedge clk);
      check("R8 follow", {15'd0, dfi_cs_n, dfi_address}, {15'd0, 1'b1, 16'h0F0F});
      check("R8 odt follow", {31'd0, dfi_odt}, 32'h1);
      bus(1, 0, 32'h0);
      check("R8 back to sw", {29'd0, s_ctl}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      t_reset();
      t_control();
      t_cmd_alone();
      t_mrs();
      t_zq();
      t_issue_zero();
      t_readback();
      t_hw_own();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule